// File: doc/BRIEF.md
# Shared-Bus Arbiter with Atomic Test-and-Set

This block sits between several processors and one small shared word memory. Each processor raises a request carrying an operation (read, write or swap), a word address and write data. Every cycle the arbiter picks at most one requester in round-robin order and performs its access in that same transaction. Because only one access reaches the memory per cycle, all accesses from all processors form a single serial order.

The swap operation is a test-and-set. In one granted transaction it returns the word's previous value and stores the locked value (1) in its place, and no other access can fall between the read and the write. When several processors race on a free lock word, exactly one of them sees 0 and takes the lock. A later ordinary write of 0 releases the lock.

A requester holds its request and its fields steady until it sees its grant bit. The grant is asserted combinationally in the cycle the access is accepted. One cycle later a done pulse marks the response, and the shared read-data bus carries the result.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After reset every memory word reads as 0, and `grant`, `rsp_done` and `rsp_rdata` are all 0.
- R2: `grant` has at most one bit set, and it is set only for a requester whose `req_valid` bit is high. A grant is given in every cycle where at least one request is valid.
- R3: The search for the next grant starts with the requester after the one granted last and wraps around. After reset, requester 0 has first priority.
- R4: In the cycle after requester i is granted, `rsp_done` is exactly bit i for one cycle. `rsp_rdata` then holds the value the addressed word had before the access, and the value stays until the next response.
- R5: Operation codes are 2'b00 read, 2'b01 write, 2'b10 swap, and 2'b11 acts as a read. A write stores the write data in the addressed word.
- R6: A swap stores 1 in the addressed word and returns the old value. Both happen in the same granted transaction.
- R7: When several requesters swap the same zero word, exactly one of them receives 0 and all the others receive 1.
- R8: Writing 0 to a locked word releases it, so the next swap on that word receives 0.
- R9: A read, including opcode 2'b11, leaves the addressed word unchanged and ignores the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_op | input | 2*N_REQ | Operation code, 2 bits per requester |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_wdata | input | N_REQ*DATA_W | Write data per requester |
| grant | output | N_REQ | One-hot grant, asserted in the cycle the access is taken |
| rsp_done | output | N_REQ | One-cycle completion pulse, the cycle after the grant |
| rsp_rdata | output | DATA_W | Previous word value for the completed access |

## Verification
The bench first sweeps reads across every address to confirm the cleared memory. It then runs crossed write and read-back traffic, which shows whether write data and addresses reach the right words. Requests from only two requesters, in a sparse pattern, separate true round-robin rotation from fixed priority. All requesters swapping one zero word in the same cycle, and then an unlock followed by two contenders, show whether exactly one winner sees 0. A long random mix of all four opcodes is compared against a behavioural model cycle by cycle, so any break in serial order or in swap atomicity shows up as a mismatch.

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter #(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LOCK_VAL = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  input  logic [2*N_REQ-1:0]       req_op,
  input  logic [N_REQ*ADDR_W-1:0]  req_addr,
  input  logic [N_REQ*DATA_W-1:0]  req_wdata,
  output logic [N_REQ-1:0]         grant,
  output logic [N_REQ-1:0]         rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata
);
  // N_REQ must be a power of two of at least 2 (pointer wraps by overflow)
  localparam int DEPTH = 1 << ADDR_W;
  localparam int IDX_W = $clog2(N_REQ);
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_SWAP  = 2'b10;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  last_q, win, idx;
  logic              any;

  always_comb begin
    any = 1'b0;
    win = last_q;
    idx = last_q;
    for (int k = 1; k <= N_REQ; k++) begin
      idx = last_q + IDX_W'(k);
      if (!any && req_valid[idx]) begin
        any = 1'b1;
        win = idx;
      end
    end
  end

  assign grant = any ? (N_REQ'(1) << win) : '0;

  logic [1:0]        win_op;
  logic [ADDR_W-1:0] win_addr;
  logic [DATA_W-1:0] win_wdata, old_word;
  assign win_op    = req_op[win*2 +: 2];
  assign win_addr  = req_addr[win*ADDR_W +: ADDR_W];
  assign win_wdata = req_wdata[win*DATA_W +: DATA_W];
  assign old_word  = mem[win_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= IDX_W'(N_REQ - 1);
      rsp_done  <= '0;
      rsp_rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      rsp_done <= grant;
      if (any) begin
        last_q    <= win;
        rsp_rdata <= old_word;
        if (win_op == OP_WRITE)     mem[win_addr] <= win_wdata;
        else if (win_op == OP_SWAP) mem[win_addr] <= LOCK_VAL;
      end
    end
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req_valid) == '0));
  a_r2_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid != '0) |-> (grant != '0));
  a_r4_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (rsp_done == $past(grant)) && (rsp_rdata == $past(old_word)));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> (rsp_done == '0) && $stable(rsp_rdata));
  a_r5_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (any && win_op == OP_WRITE) |=> mem[$past(win_addr)] == $past(win_wdata));
  a_r6_swap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (any && win_op == OP_SWAP) |=> mem[$past(win_addr)] == LOCK_VAL);
  a_r9_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (any && win_op[0] == win_op[1]) |=> mem[$past(win_addr)] == $past(old_word));
endmodule

// File: tb/bus_lock_arbiter_tb.sv
module bus_lock_arbiter_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0]   req_valid = '0;
  logic [7:0]   req_op = '0;
  logic [15:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [3:0]   grant, rsp_done;
  logic [31:0]  rsp_rdata;

  bus_lock_arbiter u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [1:0]  p_op  [4][256];
  logic [3:0]  p_addr[4][256];
  logic [31:0] p_dat [4][256];
  int cnt[4], head[4];
  logic [31:0] m_mem[16];
  int m_last = 3;
  logic [3:0]  exp_done = '0;
  logic [31:0] exp_rdata = '0;
  logic [1:0]  pend_op;
  logic [3:0]  pend_addr;
  int tally_addr = -1, zeros = 0, swaps = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input int r, input logic [1:0] op, input logic [3:0] a, input logic [31:0] d);
    p_op[r][cnt[r]] = op; p_addr[r][cnt[r]] = a; p_dat[r][cnt[r]] = d; cnt[r]++;
  endtask

  task automatic clear_prog();
    for (int r = 0; r < 4; r++) begin cnt[r] = 0; head[r] = 0; end
  endtask

  task automatic step();
    int w;
    @(negedge clk);
    chk(rsp_done == exp_done, "R4 done pulse", {28'd0, rsp_done}, {28'd0, exp_done});
    if (exp_done != 0) begin
      chk(rsp_rdata == exp_rdata, "R4/R5/R6/R9 rdata", rsp_rdata, exp_rdata);
      if (pend_op == 2'b10 && int'(pend_addr) == tally_addr) begin
        swaps++;
        if (rsp_rdata == 0) zeros++;
      end
    end
    for (int r = 0; r < 4; r++) begin
      req_valid[r] = head[r] < cnt[r];
      req_op[r*2 +: 2]     = req_valid[r] ? p_op[r][head[r]] : 2'b00;
      req_addr[r*4 +: 4]   = req_valid[r] ? p_addr[r][head[r]] : 4'h0;
      req_wdata[r*32 +: 32] = req_valid[r] ? p_dat[r][head[r]] : $urandom;
    end
    #1;
    w = -1;
    for (int k = 1; k <= 4; k++)
      if (w < 0 && req_valid[(m_last + k) % 4]) w = (m_last + k) % 4;
    chk(grant == ((w < 0) ? 4'b0 : 4'(1 << w)), "R2/R3 grant", {28'd0, grant},
        (w < 0) ? 32'd0 : 32'(1 << w));
    if (w >= 0) begin
      pend_op = p_op[w][head[w]]; pend_addr = p_addr[w][head[w]];
      exp_rdata = m_mem[pend_addr];
      if (pend_op == 2'b01) m_mem[pend_addr] = p_dat[w][head[w]];
      else if (pend_op == 2'b10) m_mem[pend_addr] = 32'd1;
      head[w]++; m_last = w; exp_done = 4'(1 << w);
    end else exp_done = '0;
  endtask

  task automatic run();
    bit busy = 1;
    while (busy) begin
      step();
      busy = 0;
      for (int r = 0; r < 4; r++) if (head[r] < cnt[r]) busy = 1;
    end
    step(); step();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    clear_prog();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(grant == 0 && rsp_done == 0, "R1 reset outputs", {24'd0, grant, rsp_done}, 32'd0);
    chk(rsp_rdata == 0, "R1 reset rdata", rsp_rdata, 32'd0);
    // R1: every word reads zero after reset
    clear_prog();
    for (int r = 0; r < 4; r++) for (int j = 0; j < 4; j++) push(r, 2'b00, 4'(r*4+j), $urandom);
    run();
    // R5: crossed write then read back
    clear_prog();
    for (int r = 0; r < 4; r++) for (int j = 0; j < 4; j++) push(r, 2'b01, 4'(r*4+j), 32'hA000_0000 + 32'(r*16+j));
    for (int r = 0; r < 4; r++) for (int j = 0; j < 4; j++) push(r, 2'b00, 4'(((r+1)%4)*4+j), $urandom);
    run();
    // R3: two requesters only, rotation check
    clear_prog();
    for (int j = 0; j < 3; j++) begin push(1, 2'b00, 4'(j), 0); push(3, 2'b00, 4'(j+4), 0); end
    push(3, 2'b00, 4'd7, 0);
    run();
    // R7: all four swap a zero word at once
    clear_prog(); m_mem[9] = m_mem[9];
    push(0, 2'b01, 4'd9, 32'd0); run();
    clear_prog(); tally_addr = 9; zeros = 0; swaps = 0;
    for (int r = 0; r < 4; r++) push(r, 2'b10, 4'd9, $urandom);
    run();
    chk(zeros == 1 && swaps == 4, "R7 single winner", 32'(zeros), 32'd1);
    chk(m_mem[9] == 1, "R6 lock set in model", m_mem[9], 32'd1);
    // R8: unlock by plain write, then two contenders
    clear_prog(); push(1, 2'b01, 4'd9, 32'd0); run();
    clear_prog(); zeros = 0; swaps = 0;
    push(2, 2'b10, 4'd9, 0); push(3, 2'b10, 4'd9, 0);
    run();
    chk(zeros == 1 && swaps == 2, "R8 unlock then one winner", 32'(zeros), 32'd1);
    tally_addr = -1;
    // R9: opcode 11 and 00 leave word untouched
    clear_prog();
    push(2, 2'b11, 4'd9, 32'hDEAD_BEEF); push(2, 2'b00, 4'd9, 32'hCAFE_F00D); push(2, 2'b00, 4'd9, 0);
    run();
    // random mixed traffic, R2 R4 R5 R6 R9
    clear_prog();
    for (int r = 0; r < 4; r++) for (int j = 0; j < 200; j++)
      push(r, 2'($urandom), 4'($urandom), $urandom);
    run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule